// File: doc/BRIEF.md
# Load/Store Lane Unit

This block sits between an execute stage and a 32-bit data memory port. From a base operand and either a register offset or an immediate offset it forms the effective address. It then forces that address to the natural alignment of the access size, and it drives one byte-enable per byte lane. Stores get write data copied onto the correct lanes. Loads get read data cut out of the returned word and zero-extended.

An access whose address is misaligned does not trap. The low address bits are cleared silently. Lanes are numbered big-endian: address offset 0 is the most significant byte of the bus. The memory is treated as a synchronous read. The request is presented in one cycle, the memory returns its word in the following cycle, and the unit extracts the load result in that following cycle using the size and lane offset it captured on the request edge.

Top module: `lsu_lane_unit`

## Requirements
- R1: The effective address is `base_val + imm_off` when `use_imm` is 1 and `base_val + reg_off` when it is 0, taken modulo 2^32. The unused offset has no effect on `mem_addr`.
- R2: For a byte access (`req_size` = 00), `mem_addr` equals the effective address with no bits changed.
- R3: For a halfword access (`req_size` = 01), `mem_addr` is the effective address with bit 0 cleared. For a word access (`req_size` = 10, and also 11), bits 1 and 0 are cleared.
- R4: `mem_be` has one bit per byte lane. Bit 3 covers data bits 31:24 (offset 0) and bit 0 covers bits 7:0 (offset 3). A byte access sets only bit 3-offset. A halfword sets 1100 at offset 0 and 0011 at offset 2. A word sets 1111. Loads and stores use the same enables.
- R5: While `req_valid` is 0, `mem_be` is 0000 and `mem_we` is 0, and `load_valid` is 0 in the following cycle.
- R6: `mem_we` equals `req_valid & req_store`. For a byte store, the low byte of `store_src` appears on all four lanes. For a halfword store, the low halfword of `store_src` appears on both halves. For a word store, `store_src` appears unchanged.
- R7: A load request (`req_valid`=1, `req_store`=0) raises `load_valid` for exactly the next cycle. `load_data` is then formed from the `mem_rdata` presented in that cycle.
- R8: A byte load returns the lane at the aligned offset, zero-extended. Offset 0 gives `mem_rdata[31:24]` and offset 3 gives `mem_rdata[7:0]`.
- R9: A halfword load returns `mem_rdata[31:16]` at offset 0 or `mem_rdata[15:0]` at offset 2, zero-extended.
- R10: A word load returns `mem_rdata` unchanged.
- R11: While `rst_n` is low, `load_valid` is 0.
- R12: A store request never raises `load_valid` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| use_imm | input | 1 | Select immediate offset instead of register offset |
| base_val | input | 32 | Base operand |
| reg_off | input | 32 | Register offset operand |
| imm_off | input | 32 | Immediate offset operand |
| store_src | input | 32 | Store source operand (low bits used for sub-word stores) |
| mem_addr | output | 32 | Aligned memory address |
| mem_be | output | 4 | Per-lane byte enables, bit 3 = bits 31:24 |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_rdata | input | 32 | Read word, valid the cycle after a load request |
| load_valid | output | 1 | Load result valid |
| load_data | output | 32 | Zero-extended load result |

## Verification
The bench sweeps every size code, including the spare code 11, against every low-address offset. Each combination runs with both offset sources, as both load and store, and on bases chosen so that the address wraps through zero. The wrap case catches an adder that is truncated or sign-extended. Running the odd offsets at halfword and word size catches an aligner that keeps a low bit, which would show up as a wrong `mem_addr` and enables that straddle a lane boundary. The load check catches a little-endian lane order or a shift that is off by one lane, either of which would return the mirrored byte. The check for the cycle after a store catches a `load_valid` that ignores the direction bit.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE     = 2'b00,
    SZ_HALF     = 2'b01,
    SZ_WORD     = 2'b10,
    SZ_WORD_ALT = 2'b11
  } acc_size_e;

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_LANES = 4,
  localparam int OFF_W    = $clog2(NUM_LANES)
) (
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] reg_off,
  input  logic [ADDR_W-1:0] imm_off,
  input  logic              use_imm,
  input  acc_size_e         size,
  output logic [ADDR_W-1:0] addr_aligned,
  output logic [OFF_W-1:0]  lane_off
);

  logic [ADDR_W-1:0] ea;
  logic [ADDR_W-1:0] low_clr;

  // effective address: base plus selected offset, wraps modulo 2^ADDR_W
  always_comb begin
    ea = base_val + (use_imm ? imm_off : reg_off);
  end

  // natural alignment: clear the low bits covered by the access span
  always_comb begin
    case (size)
      SZ_BYTE: low_clr = '0;
      SZ_HALF: low_clr = ADDR_W'(1);
      default: low_clr = ADDR_W'(NUM_LANES - 1);
    endcase
    addr_aligned = ea & ~low_clr;
    lane_off     = addr_aligned[OFF_W-1:0];
  end

endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_pkg::*;
#(
  parameter int DATA_W    = 32,
  localparam int NUM_LANES = DATA_W / 8,
  localparam int OFF_W     = $clog2(NUM_LANES)
) (
  input  logic                 active,
  input  acc_size_e            size,
  input  logic [OFF_W-1:0]     lane_off,
  input  logic [DATA_W-1:0]    store_src,
  output logic [NUM_LANES-1:0] be,
  output logic [DATA_W-1:0]    wdata
);

  logic [OFF_W:0] span;
  logic [OFF_W:0] lo_pos;
  logic [OFF_W:0] hi_pos;

  always_comb begin
    case (size)
      SZ_BYTE: span = (OFF_W+1)'(1);
      SZ_HALF: span = (OFF_W+1)'(2);
      default: span = (OFF_W+1)'(NUM_LANES);
    endcase
    lo_pos = {1'b0, lane_off};
    hi_pos = lo_pos + span;
  end

  // lane g sits at big-endian position g: bits [DATA_W-1-8g -: 8], enable bit NUM_LANES-1-g
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int BIT_LO = DATA_W - 8 - 8 * g;
    localparam int HALF_SEL = (NUM_LANES - 1 - g) % 2;

    always_comb begin
      be[NUM_LANES-1-g] = active &&
                          ((OFF_W+1)'(g) >= lo_pos) &&
                          ((OFF_W+1)'(g) <  hi_pos);
    end

    // replicate the low element so every enabled lane carries the right byte
    always_comb begin
      case (size)
        SZ_BYTE: wdata[BIT_LO +: 8] = store_src[7:0];
        SZ_HALF: wdata[BIT_LO +: 8] = store_src[8*HALF_SEL +: 8];
        default: wdata[BIT_LO +: 8] = store_src[BIT_LO +: 8];
      endcase
    end
  end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
#(
  parameter int DATA_W    = 32,
  localparam int NUM_LANES = DATA_W / 8,
  localparam int OFF_W     = $clog2(NUM_LANES),
  localparam int SH_W      = OFF_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  acc_size_e         size_in,
  input  logic [OFF_W-1:0]  off_in,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              load_valid,
  output logic [DATA_W-1:0] load_data
);

  logic             pend_q, pend_d;
  acc_size_e        size_q, size_d;
  logic [OFF_W-1:0] off_q, off_d;

  logic [OFF_W:0]    lane_pos;
  logic [SH_W-1:0]   shamt;
  logic [DATA_W-1:0] keep_mask;

  // next state: capture the access shape only when a load is accepted
  always_comb begin
    pend_d = cap_en;
    size_d = size_q;
    off_d  = off_q;
    if (cap_en) begin
      size_d = size_in;
      off_d  = off_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      size_q <= SZ_WORD;
      off_q  <= '0;
    end else begin
      pend_q <= pend_d;
      size_q <= size_d;
      off_q  <= off_d;
    end
  end

  // lane_pos = number of lanes below the selected element
  always_comb begin
    case (size_q)
      SZ_BYTE: begin
        lane_pos  = (OFF_W+1)'(NUM_LANES - 1) - {1'b0, off_q};
        keep_mask = DATA_W'(8'hFF);
      end
      SZ_HALF: begin
        lane_pos  = (OFF_W+1)'(NUM_LANES - 2) - {1'b0, off_q};
        keep_mask = DATA_W'(16'hFFFF);
      end
      default: begin
        lane_pos  = '0;
        keep_mask = '1;
      end
    endcase
    shamt     = {lane_pos, 3'b000};
    load_data = (mem_rdata >> shamt) & keep_mask;
  end

  assign load_valid = pend_q;

endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int NUM_LANES = DATA_W / 8,
  localparam int OFF_W     = $clog2(NUM_LANES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_store,
  input  logic [1:0]           req_size,
  input  logic                 use_imm,
  input  logic [ADDR_W-1:0]    base_val,
  input  logic [ADDR_W-1:0]    reg_off,
  input  logic [ADDR_W-1:0]    imm_off,
  input  logic [DATA_W-1:0]    store_src,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [NUM_LANES-1:0] mem_be,
  output logic                 mem_we,
  output logic [DATA_W-1:0]    mem_wdata,
  input  logic [DATA_W-1:0]    mem_rdata,
  output logic                 load_valid,
  output logic [DATA_W-1:0]    load_data
);

  acc_size_e        size_e;
  logic [OFF_W-1:0] lane_off;
  logic             load_req;

  assign size_e   = acc_size_e'(req_size);
  assign load_req = req_valid & ~req_store;
  assign mem_we   = req_valid & req_store;

  lsu_addr_gen #(
    .ADDR_W    (ADDR_W),
    .NUM_LANES (NUM_LANES)
  ) u_addr (
    .base_val     (base_val),
    .reg_off      (reg_off),
    .imm_off      (imm_off),
    .use_imm      (use_imm),
    .size         (size_e),
    .addr_aligned (mem_addr),
    .lane_off     (lane_off)
  );

  lsu_store_lanes #(
    .DATA_W (DATA_W)
  ) u_lanes (
    .active    (req_valid),
    .size      (size_e),
    .lane_off  (lane_off),
    .store_src (store_src),
    .be        (mem_be),
    .wdata     (mem_wdata)
  );

  lsu_load_extract #(
    .DATA_W (DATA_W)
  ) u_load (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_en     (load_req),
    .size_in    (size_e),
    .off_in     (lane_off),
    .mem_rdata  (mem_rdata),
    .load_valid (load_valid),
    .load_data  (load_data)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (mem_be == '0) && !mem_we);                                 // R5
  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'b00) |-> $countones(mem_be) == 1);             // R4
  AST_WORD_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size[1]) |-> (mem_be == '1));                            // R4
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size[1]) |-> (mem_addr[OFF_W-1:0] == '0));               // R3
  AST_HALF_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'b01) |-> !mem_addr[0]);                        // R3
  AST_LOAD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_store) |=> load_valid);                                 // R7
  AST_STORE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store) |=> !load_valid);                                 // R12
  AST_IDLE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !load_valid);                                               // R5

endmodule

// File: tb/lsu_lane_unit_tb_top.sv
`timescale 1ns/1ps
module lsu_lane_unit_tb_top;

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_store, use_imm;
  logic [1:0]  req_size;
  logic [31:0] base_val, reg_off, imm_off, store_src, mem_rdata;
  logic [31:0] mem_addr, mem_wdata, load_data;
  logic [3:0]  mem_be;
  logic        mem_we, load_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  lsu_lane_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .use_imm(use_imm), .base_val(base_val),
    .reg_off(reg_off), .imm_off(imm_off), .store_src(store_src),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .load_valid(load_valid), .load_data(load_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_be(input int n, input int off);
    logic [3:0] r = 4'b0000;
    for (int l = 0; l < 4; l++)
      if (l >= off && l < off + n) r[3-l] = 1'b1;
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] bases [3];
    bases[0] = 32'h0000_1000;
    bases[1] = 32'hFFFF_FFF0;
    bases[2] = 32'h7654_3218;

    rst_n = 1'b0; req_valid = 1'b0; req_store = 1'b0; req_size = 2'b00;
    use_imm = 1'b0; base_val = '0; reg_off = '0; imm_off = '0;
    store_src = '0; mem_rdata = '0;
    repeat (3) @(posedge clk);
    #2;
    check(load_valid == 1'b0, "R11 load_valid in reset", {31'b0, load_valid}, 32'h0);
    check(mem_be == 4'b0 && !mem_we, "R5 idle enables in reset", {27'b0, mem_we, mem_be}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int bi = 0; bi < 3; bi++)
      for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 4; off++)
          for (int im = 0; im < 2; im++)
            for (int st = 0; st < 2; st++) begin
              logic [31:0] offs, ea, ea_exp, wd_exp, rd, ld_exp;
              int n, aoff;
              @(negedge clk);
              // previous cycle was idle or a store: no load result now
              check(load_valid == 1'b0, "R5/R12 load_valid after idle",
                    {31'b0, load_valid}, 32'h0);
              offs      = 32'h0000_0104 + off;
              req_valid = 1'b1;
              req_store = st[0];
              req_size  = sz[1:0];
              use_imm   = im[0];
              base_val  = bases[bi];
              reg_off   = im ? 32'h5555_5557 : offs;
              imm_off   = im ? offs : 32'hAAAA_AAA9;
              store_src = 32'h9A3C_5E71 + off * 32'h0101_0101 + bi * 32'h1111_0000;
              ea = bases[bi] + offs;
              n  = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
              ea_exp = (sz == 0) ? ea : (sz == 1) ? (ea & ~32'h1) : (ea & ~32'h3);
              aoff   = int'(ea_exp[1:0]);
              wd_exp = (sz == 0) ? {4{store_src[7:0]}} :
                       (sz == 1) ? {2{store_src[15:0]}} : store_src;
              #2;
              if (sz == 0) check(mem_addr == ea_exp, "R2 byte address", mem_addr, ea_exp);
              else         check(mem_addr == ea_exp, "R3 aligned address", mem_addr, ea_exp);
              check(mem_addr == ea_exp, "R1 offset select/wrap", mem_addr, ea_exp);
              check(mem_be == exp_be(n, aoff), "R4 byte enables",
                    {28'b0, mem_be}, {28'b0, exp_be(n, aoff)});
              check(mem_we == st[0], "R6 write strobe", {31'b0, mem_we}, {31'b0, st[0]});
              if (st) check(mem_wdata == wd_exp, "R6 store lanes", mem_wdata, wd_exp);
              @(negedge clk);
              req_valid = 1'b0;
              rd = 32'hC1D2_E3F4 ^ (off * 32'h0F0F_0F0F) ^ (bi * 32'h2468_0000);
              mem_rdata = rd;
              ld_exp = (rd >> ((4 - n - aoff) * 8)) &
                       ((n == 1) ? 32'hFF : (n == 2) ? 32'hFFFF : 32'hFFFF_FFFF);
              #2;
              check(mem_be == 4'b0 && !mem_we, "R5 idle enables",
                    {27'b0, mem_we, mem_be}, 32'h0);
              if (st) begin
                check(load_valid == 1'b0, "R12 no load after store",
                      {31'b0, load_valid}, 32'h0);
              end else begin
                check(load_valid == 1'b1, "R7 load_valid timing",
                      {31'b0, load_valid}, 32'h1);
                if (sz == 0)      check(load_data == ld_exp, "R8 byte load", load_data, ld_exp);
                else if (sz == 1) check(load_data == ld_exp, "R9 half load", load_data, ld_exp);
                else              check(load_data == ld_exp, "R10 word load", load_data, ld_exp);
              end
            end

    @(negedge clk);
    #2;
    check(load_valid == 1'b0, "R5 load_valid after final idle", {31'b0, load_valid}, 32'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule